// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports, 24 lines in all, behind a small register interface. The processor uses an 8-bit data bus, a 2-bit address and active-low select, read and write strobes. Two address values reach the ports, one reaches the third port, and the fourth reaches a control address. A write to the control address does one of two things. It either redefines every port's direction or forces a single line of the third port high or low. The third port splits into two 4-bit halves, and each half has its own direction. The upper half belongs with port A in group A. The lower half belongs with port B in group B.

Only plain unhandshaked transfers are carried out. A control word that asks for a strobed or bidirectional mode raises a sticky flag, and the ports still work as plain I/O. Each pad is modelled as three vectors: one for the level read from the pin, one for the driven value and one for the output enable. All state is synchronous to `clk`. A strobe acts on every rising edge on which it is seen together with the select.

Top module: `ppio_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, every output enable is 0, every driven value is 0 and `mode_err` is 0. Until a control word is written, no line is driven.
- R2: The address selects the target: 0 is port A, 1 is port B, 2 is port C, 3 is the control address. A read of a port set as input returns the level on its pins that cycle.
- R3: A write to a port address loads that port's latch on the next rising edge. A port set as output drives its latch on its pins with all enables high, and a read of it returns the latch.
- R4: A control write with data bit 7 = 1 is a mode word. Bit 4 sets port A's direction, bit 3 sets the upper half of C, bit 1 sets port B and bit 0 sets the lower half of C. For each of these bits, 1 means input (enables low) and 0 means output.
- R5: Every mode word clears the latches of ports A, B and C to zero.
- R6: A control write with bit 7 = 0 changes only port C latch bit number data[3:1] to the value data[0]. The other seven latch bits, all directions and `mode_err` stay unchanged, and bits 6:4 have no effect.
- R7: A mode word with bits 6:5 not equal to 00, or with bit 2 = 1, sets `mode_err`. A mode word with all three bits zero clears it. In both cases the direction bits apply as for plain I/O.
- R8: `dout_oe` is high only while `cs_n` and `rd_n` are both low. `dout` is 0 when `dout_oe` is low, and it is 0 for a read of the control address.
- R9: When read and write strobes are both active in one cycle, the read returns the value from before that cycle's write, and the write takes effect at the edge.
- R10: A strobe seen with `cs_n` high has no effect on any latch, direction or flag.
- R11: A port C read takes each half separately: from the pins for a half set as input and from the latch for a half set as output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_oe | output | 1 | Read data bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C driven values |
| pc_oe | output | 8 | Port C output enables |
| mode_err | output | 1 | Last mode word asked for an unsupported mode |

## Verification
A port read and a port write can fall in the same cycle when the processor drives both strobes low together. The bench provokes this on an output port that holds a known value and writes a different value in that cycle. It samples `dout` before the edge, where the old value must appear. It samples the pins after the edge, where the new value must appear. The direction sweep, the bit set/reset sweep and the unsupported-mode sweep each compute their expected values from the data words themselves.

// File: rtl/ppio_pkg.sv
// Package: shared address codes, control word field positions and the
// direction record used by the parallel port controller.
// Assumes an 8-bit data path; field positions are fixed by the bus protocol.
package ppio_pkg;

    localparam logic [1:0] ADR_A   = 2'd0;
    localparam logic [1:0] ADR_B   = 2'd1;
    localparam logic [1:0] ADR_C   = 2'd2;
    localparam logic [1:0] ADR_CTL = 2'd3;

    // Control word bit positions
    localparam int F_KIND   = 7;   // 1: mode word, 0: single-bit update
    localparam int F_MODEA1 = 6;
    localparam int F_MODEA0 = 5;
    localparam int F_DIRA   = 4;
    localparam int F_DIRCU  = 3;
    localparam int F_MODEB  = 2;
    localparam int F_DIRB   = 1;
    localparam int F_DIRCL  = 0;
    localparam int F_BVAL   = 0;
    localparam int F_BIDX_LO = 1;

    // Direction per group member, 1 = input
    typedef struct packed {
        logic in_a;
        logic in_cu;
        logic in_b;
        logic in_cl;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{in_a: 1'b1, in_cu: 1'b1, in_b: 1'b1, in_cl: 1'b1};

endpackage

// File: rtl/ppio_cfg.sv
// Module: control word decoder and configuration register.
// Holds the four direction bits and the unsupported-mode flag, and turns a
// control-address write into either a latch-clear pulse (mode word) or a
// single-bit update command for port C.
// Assumes cfg_wr is a one-cycle qualified write to the control address.
module ppio_cfg
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [DW-1:0]          wdata,
    output dir_t                   dir,
    output logic                   mode_err,
    output logic                   clr_latch,
    output logic                   bsr_go,
    output logic [$clog2(DW)-1:0]  bsr_idx,
    output logic                   bsr_val
);
    localparam int IW = $clog2(DW);

    dir_t dir_q;
    logic err_q;
    logic is_mode;
    logic bad_mode;

    // Classify the control write and extract the single-bit update fields
    always_comb begin
        is_mode   = wdata[F_KIND];
        bad_mode  = wdata[F_MODEA1] | wdata[F_MODEA0] | wdata[F_MODEB];
        clr_latch = cfg_wr & is_mode;
        bsr_go    = cfg_wr & ~is_mode;
        bsr_idx   = wdata[F_BIDX_LO +: IW];
        bsr_val   = wdata[F_BVAL];
    end

    // Configuration register: directions and sticky unsupported-mode flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_ALL_IN;
            err_q <= 1'b0;
        end else if (cfg_wr && is_mode) begin
            dir_q.in_a  <= wdata[F_DIRA];
            dir_q.in_cu <= wdata[F_DIRCU];
            dir_q.in_b  <= wdata[F_DIRB];
            dir_q.in_cl <= wdata[F_DIRCL];
            err_q       <= bad_mode;
        end
    end

    assign dir      = dir_q;
    assign mode_err = err_q;

    // R4
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wdata[F_KIND]) |=>
            (dir.in_a == $past(wdata[F_DIRA]) && dir.in_cu == $past(wdata[F_DIRCU]) &&
             dir.in_b == $past(wdata[F_DIRB]) && dir.in_cl == $past(wdata[F_DIRCL])));

    // R7
    mode_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wdata[F_KIND]) |=>
            (mode_err == ($past(wdata[F_MODEA1]) | $past(wdata[F_MODEA0]) | $past(wdata[F_MODEB]))));

    // R6
    bsr_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wdata[F_KIND]) |=> ($stable(dir) && $stable(mode_err)));

endmodule

// File: rtl/ppio_port.sv
// Module: one full-width plain I/O port (used for ports A and B).
// Holds the output latch, drives enables from a single direction bit and
// returns pins or latch for reads. Assumes ld and clr never coincide.
module ppio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic         is_input,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rdata
);
    logic [W-1:0] lat_q;

    // Output latch: cleared by reset or mode word, loaded by port write
    always_ff @(posedge clk) begin
        if (!rst_n)   lat_q <= '0;
        else if (clr) lat_q <= '0;
        else if (ld)  lat_q <= wdata;
    end

    // Drive and read-back selection from the direction bit
    always_comb begin
        pin_out = lat_q;
        pin_oe  = is_input ? '0 : '1;
        rdata   = is_input ? pin_in : lat_q;
    end

    // R5
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pin_out == '0));

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (pin_out == $past(wdata)));

endmodule

// File: rtl/ppio_portc.sv
// Module: port C, split into two halves with separate direction bits.
// Supports whole-port writes, mode-word clears and single-bit updates.
// Assumes at most one of ld, clr and bsr is active in a cycle.
module ppio_portc #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld,
    input  logic                  clr,
    input  logic                  bsr,
    input  logic [$clog2(W)-1:0]  bsr_idx,
    input  logic                  bsr_val,
    input  logic [W-1:0]          wdata,
    input  logic [1:0]            half_in,   // [1] upper, [0] lower; 1 = input
    input  logic [W-1:0]          pin_in,
    output logic [W-1:0]          pin_out,
    output logic [W-1:0]          pin_oe,
    output logic [W-1:0]          rdata
);
    localparam int HW = W / 2;

    logic [W-1:0] lat_q;
    logic [W-1:0] bit_mask;

    // One-hot mask of the bit addressed by a single-bit update
    always_comb bit_mask = {{(W-1){1'b0}}, 1'b1} << bsr_idx;

    // Output latch with whole-port load and single-bit update
    always_ff @(posedge clk) begin
        if (!rst_n)   lat_q <= '0;
        else if (clr) lat_q <= '0;
        else if (ld)  lat_q <= wdata;
        else if (bsr) lat_q <= bsr_val ? (lat_q | bit_mask) : (lat_q & ~bit_mask);
    end

    assign pin_out = lat_q;

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            // Per-half enable and read-back selection
            always_comb begin
                pin_oe[h*HW +: HW] = half_in[h] ? '0 : '1;
                rdata[h*HW +: HW]  = half_in[h] ? pin_in[h*HW +: HW] : lat_q[h*HW +: HW];
            end
        end
    endgenerate

    // R6
    bsr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsr && !ld && !clr) |=> (pin_out[$past(bsr_idx)] == $past(bsr_val)));

    // R6
    bsr_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsr && !ld && !clr) |=> (((pin_out ^ $past(pin_out)) & ~$past(bit_mask)) == '0));

endmodule

// File: rtl/ppio_ctrl.sv
// Module: top of the programmable parallel port controller.
// Qualifies bus strobes, routes writes to the ports or the control decoder,
// and multiplexes read data. Reads are combinational and see state from
// before any write in the same cycle. Assumes strobes are synchronous to clk.
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic          mode_err
);
    localparam int IW = $clog2(DW);

    logic          wr_q, rd_q;
    logic          ld_a, ld_b, ld_c, cfg_wr;
    logic          clr_latch, bsr_go, bsr_val;
    logic [IW-1:0] bsr_idx;
    dir_t          dir;
    logic [DW-1:0] rd_a, rd_b, rd_c;

    // Strobe qualification and write address decode
    always_comb begin
        wr_q   = ~cs_n & ~wr_n;
        rd_q   = ~cs_n & ~rd_n;
        ld_a   = wr_q && (addr == ADR_A);
        ld_b   = wr_q && (addr == ADR_B);
        ld_c   = wr_q && (addr == ADR_C);
        cfg_wr = wr_q && (addr == ADR_CTL);
    end

    ppio_cfg #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .wdata     (din),
        .dir       (dir),
        .mode_err  (mode_err),
        .clr_latch (clr_latch),
        .bsr_go    (bsr_go),
        .bsr_idx   (bsr_idx),
        .bsr_val   (bsr_val)
    );

    ppio_port #(.W(DW)) u_pa (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld_a),
        .clr      (clr_latch),
        .wdata    (din),
        .is_input (dir.in_a),
        .pin_in   (pa_in),
        .pin_out  (pa_out),
        .pin_oe   (pa_oe),
        .rdata    (rd_a)
    );

    ppio_port #(.W(DW)) u_pb (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld_b),
        .clr      (clr_latch),
        .wdata    (din),
        .is_input (dir.in_b),
        .pin_in   (pb_in),
        .pin_out  (pb_out),
        .pin_oe   (pb_oe),
        .rdata    (rd_b)
    );

    ppio_portc #(.W(DW)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld_c),
        .clr      (clr_latch),
        .bsr      (bsr_go),
        .bsr_idx  (bsr_idx),
        .bsr_val  (bsr_val),
        .wdata    (din),
        .half_in  ({dir.in_cu, dir.in_cl}),
        .pin_in   (pc_in),
        .pin_out  (pc_out),
        .pin_oe   (pc_oe),
        .rdata    (rd_c)
    );

    // Read data multiplexer; zero when not reading or reading control
    always_comb begin
        dout = '0;
        if (rd_q) begin
            unique case (addr)
                ADR_A:   dout = rd_a;
                ADR_B:   dout = rd_b;
                ADR_C:   dout = rd_c;
                default: dout = '0;
            endcase
        end
    end

    assign dout_oe = rd_q;

    // R10
    no_sel_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                  $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(mode_err)));

    // R8
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == ADR_CTL) |-> (dout == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && !mode_err));

endmodule

// File: tb/tb_ppio_ctrl.sv
// Bench: sweeps every direction combination, every single-bit update and
// every unsupported mode code, with expected values computed from the words.
module tb_ppio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       mode_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ppio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .mode_err(mode_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        d = dout; oe = dout_oe;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin : watchdog
        #(5 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rv;
        logic       roe;
        logic [7:0] ea, eb, ec, ecl;
        repeat (4) @(negedge clk);
        // R1: state while and after reset
        chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
        chk("R1 out", {pa_out, pb_out, pc_out}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 err", {31'd0, mode_err}, 32'd0);
        // R1: port writes before any control word still drive nothing
        bus_wr(2'd0, 8'hFF);
        chk("R1 no drive", {pa_oe, pb_oe, pc_oe}, 24'h0);
        pa_in = 8'h96;
        bus_rd(2'd0, rv, roe);
        chk("R2 input read A", rv, 8'h96);

        // R4 R5 R2 R3 R11: sweep all direction combinations
        for (int i = 0; i < 16; i++) begin
            logic ia, icu, ib, icl;
            ia = i[3]; icu = i[2]; ib = i[1]; icl = i[0];
            pa_in = 8'h1F ^ 8'(i * 13);
            pb_in = 8'hE2 + 8'(i);
            pc_in = 8'h4B ^ 8'(i * 37);
            bus_wr(2'd3, {1'b1, 2'b00, ia, icu, 1'b0, ib, icl});
            chk("R5 clear", {pa_out, pb_out, pc_out}, 24'h0);
            chk("R7 err clear", {31'd0, mode_err}, 32'd0);
            chk("R4 oe", {pa_oe, pb_oe, pc_oe},
                {ia ? 8'h00 : 8'hFF, ib ? 8'h00 : 8'hFF, icu ? 4'h0 : 4'hF, icl ? 4'h0 : 4'hF});
            ea = 8'hA5 ^ 8'(i); eb = 8'h3C + 8'(i * 5); ec = 8'hC3 ^ 8'(i * 17);
            bus_wr(2'd0, ea);
            bus_wr(2'd1, eb);
            bus_wr(2'd2, ec);
            chk("R3 drive", {pa_out, pb_out, pc_out}, {ea, eb, ec});
            bus_rd(2'd0, rv, roe);
            chk("R2 R3 read A", rv, ia ? pa_in : ea);
            chk("R8 oe", {31'd0, roe}, 32'd1);
            bus_rd(2'd1, rv, roe);
            chk("R2 R3 read B", rv, ib ? pb_in : eb);
            bus_rd(2'd2, rv, roe);
            chk("R11 read C", rv, {icu ? pc_in[7:4] : ec[7:4], icl ? pc_in[3:0] : ec[3:0]});
            bus_rd(2'd3, rv, roe);
            chk("R8 ctl read", rv, 8'h00);
        end

        // R6: single-bit updates over every bit and value, junk in bits 6:4
        bus_wr(2'd3, 8'h80);
        ecl = 8'h00;
        for (int k = 0; k < 16; k++) begin
            logic [2:0] idx;
            logic       v;
            idx = 3'(k * 3);
            v = ~k[0];
            if (k >= 8) v = k[0];
            bus_wr(2'd3, {1'b0, 3'(k * 5), idx, v});
            if (v) ecl = ecl | (8'd1 << idx); else ecl = ecl & ~(8'd1 << idx);
            chk("R6 bit update", pc_out, ecl);
            chk("R6 dirs kept", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
        end

        // R7: unsupported mode codes flagged, ports keep plain behaviour
        for (int m = 1; m < 8; m++) begin
            bus_wr(2'd3, {1'b1, 2'(m >> 1), 1'b0, 1'b0, m[0], 1'b0, 1'b0});
            chk("R7 err set", {31'd0, mode_err}, 32'd1);
            bus_wr(2'd0, 8'(m * 29));
            chk("R7 plain drive", {pa_out, pa_oe}, {8'(m * 29), 8'hFF});
        end
        bus_wr(2'd3, 8'h0F);
        chk("R6 err kept", {31'd0, mode_err}, 32'd1);
        bus_wr(2'd3, 8'h80);
        chk("R7 err cleared", {31'd0, mode_err}, 32'd0);

        // R9: read and write together on port A
        bus_wr(2'd0, 8'h11);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; din = 8'h22;
        #1;
        chk("R9 old value", dout, 8'h11);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        chk("R9 new value", pa_out, 8'h22);

        // R10: strobes without select
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hEE;
        @(negedge clk);
        addr = 2'd3; din = 8'h9F;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R8 no oe without select", {dout_oe, dout}, 9'h000);
        rd_n = 1'b1;
        chk("R10 latch kept", pa_out, 8'h22);
        chk("R10 cfg kept", {pa_oe, mode_err}, 9'h1FE);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule